// File: doc/BRIEF.md
# Indexed performance counter bank

This block holds a parameterised set of event counters reached through one small register window. Software first writes a counter number into an index register. Every later access to the per-counter registers then lands on that counter: its condition selector, its two count words and its two threshold words. Each counter is tied to one bit of an incoming vector of condition pulses, chosen by the condition index in its config register. Two qualifier flags can limit counting to kernel mode or to user mode. A global run bit starts and stops every counter together. A snapshot command copies the selected counter's whole value into a read-only register pair in a single cycle, so both halves can be read without a carry splitting them.

Each counter has a 64-bit threshold. When an increment brings the count onto the threshold, the counter's interrupt-active bit is set. The interrupt output is raised while any counter has both its active and its enable bit set. Clearing an active bit by writing 1 also drops the matching enable bit, so the handler has to re-arm it. A read-only build word describes the instance: how many counters it has, their width (32 + 16·s bits) and whether it supports interrupts.

Top module: `perf_counter_bank`

## Requirements
- R1: After reset, every counter, config, threshold, interrupt-enable and interrupt-active bit reads zero, the index register reads 0, the control register reads 0 and `irq` is low.
- R2: Register addresses are BUILD=0, INDEX=1, CTRL=2, CFG=3, CNT_LO=4, CNT_HI=5, SNAP_LO=6, SNAP_HI=7, THR_LO=8, THR_HI=9, INT_EN=10, INT_ACT=11. A write to INDEX stores the low log2(counter count) bits of the data; a stored value at or above the counter count is dropped. CFG, CNT_LO/HI and THR_LO/HI reads and writes act only on the selected counter.
- R3: BUILD is read-only. It returns bit 0 = 1 (present), bits 15:8 = counter count, bit 16 = 1 (interrupts supported) and bits 19:18 = size code s.
- R4: CTRL bit 0 is the global run enable. CTRL bits 31:16 hold whatever the last CTRL write put there and read back unchanged. No counter advances while bit 0 is clear.
- R5: A counter adds one on each clock edge where run is set, its config condition index k (CFG low bits) is nonzero, condition input bit k is high and the qualifier allows it. CFG bit 30 means kernel only (`priv_user` low), bit 31 means user only (`priv_user` high), neither means both modes, and both mean never.
- R6: A config condition index of 0 is the "never" condition: that counter holds its value.
- R7: CNT_LO and CNT_HI writes preload the selected counter. A counter is 32+16·s bits wide, wraps to zero past its all-ones value, and reads zero above its width.
- R8: A CTRL write with bit 1 set copies the selected counter's value at that edge into SNAP_HI:SNAP_LO. Bit 1 always reads 0, and the snapshot pair changes only on this command; writes to it have no effect.
- R9: When an increment makes a counter equal to its 64-bit threshold (THR_HI:THR_LO), that counter's INT_ACT bit is set. A set on the same edge wins over a clear.
- R10: Writing 1s to INT_ACT clears those active bits and the same bits of INT_EN. INT_EN is written directly, one bit per counter.
- R11: `irq` is high exactly when some counter has both its INT_ACT and its INT_EN bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| cond_in | input | NUM_COND | Condition pulse vector, bit k feeds condition index k |
| priv_user | input | 1 | Current privilege mode, 1 = user, 0 = kernel |
| irq | output | 1 | Combined overflow interrupt |

## Verification
The assertions assume that a register access lasts one cycle per strobe and that `reg_addr` stays a legal address while a write is strobed. They also assume `cond_in` and `priv_user` settle before the clock edge. The bench changes every input only on the falling edge and writes only the twelve defined addresses. It sweeps each counter through every condition index, qualifier setting, privilege mode and two alternating condition patterns. This keeps the count-step and never-condition properties under load across all of their reachable cases.

// File: rtl/pcb_pkg.sv
package pcb_pkg;

  typedef enum logic [3:0] {
    RA_BUILD    = 4'd0,
    RA_INDEX    = 4'd1,
    RA_CTRL     = 4'd2,
    RA_CFG      = 4'd3,
    RA_CNT_LO   = 4'd4,
    RA_CNT_HI   = 4'd5,
    RA_SNAP_LO  = 4'd6,
    RA_SNAP_HI  = 4'd7,
    RA_THR_LO   = 4'd8,
    RA_THR_HI   = 4'd9,
    RA_INT_EN   = 4'd10,
    RA_INT_ACT  = 4'd11
  } reg_addr_e;

  localparam int CFG_KERN_BIT = 30;
  localparam int CFG_USER_BIT = 31;
  localparam int CTRL_RUN_BIT = 0;
  localparam int CTRL_SNAP_BIT = 1;

  function automatic int ctr_width(input int size_code);
    return 32 + 16 * size_code;
  endfunction

  function automatic logic [63:0] width_mask(input int w);
    if (w >= 64) return '1;
    return (64'd1 << w) - 64'd1;
  endfunction

  function automatic logic [63:0] count_step(input logic [63:0] cnt, input int w);
    return (cnt + 64'd1) & width_mask(w);
  endfunction

  function automatic logic qual_ok(input logic kern_only, input logic user_only,
                                   input logic priv_user);
    logic ok;
    unique case ({user_only, kern_only})
      2'b00:   ok = 1'b1;
      2'b01:   ok = ~priv_user;
      2'b10:   ok = priv_user;
      default: ok = 1'b0;
    endcase
    return ok;
  endfunction

  function automatic logic [31:0] build_word(input int n_ctrs, input int size_code);
    logic [31:0] w;
    w        = '0;
    w[0]     = 1'b1;
    w[15:8]  = n_ctrs[7:0];
    w[16]    = 1'b1;
    w[19:18] = size_code[1:0];
    return w;
  endfunction

endpackage

// File: rtl/pcb_counter.sv
module pcb_counter
  import pcb_pkg::*;
#(
  parameter int NUM_COND = 16,
  parameter int CIDX_W   = 4,
  parameter int CTR_W    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic [NUM_COND-1:0] cond_in,
  input  logic                priv_user,
  input  logic                wr_cfg,
  input  logic                wr_cnt_lo,
  input  logic                wr_cnt_hi,
  input  logic                wr_thr_lo,
  input  logic                wr_thr_hi,
  input  logic [31:0]         wdata,
  output logic [31:0]         cfg_o,
  output logic [63:0]         cnt_o,
  output logic [63:0]         thr_o,
  output logic                inc_o,
  output logic                hit_o
);

  localparam logic [63:0] MASK = width_mask(CTR_W);

  logic [CIDX_W-1:0] cidx_q;
  logic              kern_q;
  logic              user_q;
  logic [63:0]       cnt_q;
  logic [63:0]       thr_q;
  logic              cond_sel;
  logic [63:0]       cnt_next;
  logic              cnt_wr;

  always_comb begin
    cond_sel = 1'b0;
    if (int'(cidx_q) < NUM_COND) cond_sel = cond_in[cidx_q];
  end

  assign inc_o    = run && (cidx_q != '0) && cond_sel && qual_ok(kern_q, user_q, priv_user);
  assign cnt_next = count_step(cnt_q, CTR_W);
  assign cnt_wr   = wr_cnt_lo || wr_cnt_hi;
  assign hit_o    = inc_o && !cnt_wr && (cnt_next == thr_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cidx_q <= '0;
      kern_q <= 1'b0;
      user_q <= 1'b0;
    end else if (wr_cfg) begin
      cidx_q <= wdata[CIDX_W-1:0];
      kern_q <= wdata[CFG_KERN_BIT];
      user_q <= wdata[CFG_USER_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (wr_cnt_lo) begin
      cnt_q <= {cnt_q[63:32], wdata} & MASK;
    end else if (wr_cnt_hi) begin
      cnt_q <= {wdata, cnt_q[31:0]} & MASK;
    end else if (inc_o) begin
      cnt_q <= cnt_next;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_q <= '0;
    end else if (wr_thr_lo) begin
      thr_q <= {thr_q[63:32], wdata};
    end else if (wr_thr_hi) begin
      thr_q <= {wdata, thr_q[31:0]};
    end
  end

  always_comb begin
    cfg_o = '0;
    cfg_o[CIDX_W-1:0]   = cidx_q;
    cfg_o[CFG_KERN_BIT] = kern_q;
    cfg_o[CFG_USER_BIT] = user_q;
  end

  assign cnt_o = cnt_q;
  assign thr_o = thr_q;

endmodule

// File: rtl/pcb_irq.sv
module pcb_irq #(
  parameter int NUM_CTRS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_CTRS-1:0] hit,
  input  logic                wr_en,
  input  logic                wr_clr,
  input  logic [NUM_CTRS-1:0] wdata,
  output logic [NUM_CTRS-1:0] int_en,
  output logic [NUM_CTRS-1:0] int_act,
  output logic                irq
);

  logic [NUM_CTRS-1:0] clr_mask;

  assign clr_mask = wr_clr ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_act <= '0;
    end else begin
      int_act <= (int_act & ~clr_mask) | hit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_en <= '0;
    end else if (wr_en) begin
      int_en <= wdata;
    end else begin
      int_en <= int_en & ~clr_mask;
    end
  end

  assign irq = |(int_act & int_en);

endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank
  import pcb_pkg::*;
#(
  parameter int NUM_CTRS  = 8,
  parameter int NUM_COND  = 16,
  parameter int SIZE_CODE = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [3:0]          reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic [NUM_COND-1:0] cond_in,
  input  logic                priv_user,
  output logic                irq
);

  localparam int          CTR_W   = ctr_width(SIZE_CODE);
  localparam int          IW      = (NUM_CTRS > 1) ? $clog2(NUM_CTRS) : 1;
  localparam int          CIDX_W  = (NUM_COND > 1) ? $clog2(NUM_COND) : 1;
  localparam logic [31:0] BUILD_W = build_word(NUM_CTRS, SIZE_CODE);

  // register state
  logic [IW-1:0] idx_q;
  logic          run_q;
  logic [15:0]   ctrl_hi_q;
  logic [63:0]   snap_q;

  // per-counter views
  logic [31:0] cfg_vec [NUM_CTRS];
  logic [63:0] cnt_vec [NUM_CTRS];
  logic [63:0] thr_vec [NUM_CTRS];

  // named internal events
  logic [NUM_CTRS-1:0] ctr_inc;
  logic [NUM_CTRS-1:0] thr_hit;
  logic [NUM_CTRS-1:0] int_en;
  logic [NUM_CTRS-1:0] int_act;
  logic                idx_wr;
  logic                ctrl_wr;
  logic                snap_cmd;
  logic                cnt_wr_sel;
  logic [31:0]         sel_cfg;
  logic [63:0]         sel_cnt;
  logic [63:0]         sel_thr;
  logic                sel_inc;
  logic [IW-1:0]       idx_wdata;

  assign idx_wr     = reg_we && (reg_addr == RA_INDEX);
  assign ctrl_wr    = reg_we && (reg_addr == RA_CTRL);
  assign snap_cmd   = ctrl_wr && reg_wdata[CTRL_SNAP_BIT];
  assign cnt_wr_sel = reg_we && ((reg_addr == RA_CNT_LO) || (reg_addr == RA_CNT_HI));
  assign idx_wdata  = reg_wdata[IW-1:0];

  assign sel_cfg = cfg_vec[idx_q];
  assign sel_cnt = cnt_vec[idx_q];
  assign sel_thr = thr_vec[idx_q];
  assign sel_inc = ctr_inc[idx_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_wr && (int'(idx_wdata) < NUM_CTRS)) begin
      idx_q <= idx_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      ctrl_hi_q <= '0;
    end else if (ctrl_wr) begin
      run_q     <= reg_wdata[CTRL_RUN_BIT];
      ctrl_hi_q <= reg_wdata[31:16];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_q <= '0;
    end else if (snap_cmd) begin
      snap_q <= sel_cnt;
    end
  end

  for (genvar g = 0; g < NUM_CTRS; g++) begin : g_ctr
    logic here;
    assign here = (int'(idx_q) == g);

    pcb_counter #(
      .NUM_COND (NUM_COND),
      .CIDX_W   (CIDX_W),
      .CTR_W    (CTR_W)
    ) u_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run_q),
      .cond_in   (cond_in),
      .priv_user (priv_user),
      .wr_cfg    (here && reg_we && (reg_addr == RA_CFG)),
      .wr_cnt_lo (here && reg_we && (reg_addr == RA_CNT_LO)),
      .wr_cnt_hi (here && reg_we && (reg_addr == RA_CNT_HI)),
      .wr_thr_lo (here && reg_we && (reg_addr == RA_THR_LO)),
      .wr_thr_hi (here && reg_we && (reg_addr == RA_THR_HI)),
      .wdata     (reg_wdata),
      .cfg_o     (cfg_vec[g]),
      .cnt_o     (cnt_vec[g]),
      .thr_o     (thr_vec[g]),
      .inc_o     (ctr_inc[g]),
      .hit_o     (thr_hit[g])
    );
  end

  pcb_irq #(
    .NUM_CTRS (NUM_CTRS)
  ) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit     (thr_hit),
    .wr_en   (reg_we && (reg_addr == RA_INT_EN)),
    .wr_clr  (reg_we && (reg_addr == RA_INT_ACT)),
    .wdata   (reg_wdata[NUM_CTRS-1:0]),
    .int_en  (int_en),
    .int_act (int_act),
    .irq     (irq)
  );

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      RA_BUILD:   reg_rdata = BUILD_W;
      RA_INDEX:   reg_rdata[IW-1:0] = idx_q;
      RA_CTRL:    reg_rdata = {ctrl_hi_q, 15'd0, run_q};
      RA_CFG:     reg_rdata = sel_cfg;
      RA_CNT_LO:  reg_rdata = sel_cnt[31:0];
      RA_CNT_HI:  reg_rdata = sel_cnt[63:32];
      RA_SNAP_LO: reg_rdata = snap_q[31:0];
      RA_SNAP_HI: reg_rdata = snap_q[63:32];
      RA_THR_LO:  reg_rdata = sel_thr[31:0];
      RA_THR_HI:  reg_rdata = sel_thr[63:32];
      RA_INT_EN:  reg_rdata[NUM_CTRS-1:0] = int_en;
      RA_INT_ACT: reg_rdata[NUM_CTRS-1:0] = int_act;
      default:    reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/pcb_checker.sv
module pcb_checker
  import pcb_pkg::*;
#(
  parameter int NUM_CTRS  = 8,
  parameter int CIDX_W    = 4,
  parameter int CTR_W     = 32,
  parameter int IW        = 3,
  parameter int SIZE_CODE = 0
) (
  input logic                clk,
  input logic                rst_n,
  input logic                reg_we,
  input logic [3:0]          reg_addr,
  input logic [31:0]         reg_wdata,
  input logic [31:0]         reg_rdata,
  input logic                run_q,
  input logic [IW-1:0]       idx_q,
  input logic [31:0]         sel_cfg,
  input logic [63:0]         sel_cnt,
  input logic                sel_inc,
  input logic [63:0]         snap_q,
  input logic                cnt_wr_sel,
  input logic                idx_wr,
  input logic                snap_cmd,
  input logic [NUM_CTRS-1:0] ctr_inc,
  input logic [NUM_CTRS-1:0] thr_hit,
  input logic [NUM_CTRS-1:0] int_en,
  input logic [NUM_CTRS-1:0] int_act,
  input logic                irq
);

  logic clr_wr;
  logic en_wr;
  assign clr_wr = reg_we && (reg_addr == RA_INT_ACT);
  assign en_wr  = reg_we && (reg_addr == RA_INT_EN);

  AST_BUILD_CONST: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == RA_BUILD) |-> (reg_rdata == build_word(NUM_CTRS, SIZE_CODE))); // R3

  AST_STOPPED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (ctr_inc == '0)); // R4

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_inc && !cnt_wr_sel && !idx_wr) |=> (sel_cnt == count_step($past(sel_cnt), CTR_W))); // R5

  AST_NEVER_COND: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_cfg[CIDX_W-1:0] == '0) |-> !sel_inc); // R6

  AST_SNAP_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    snap_cmd |=> (snap_q == $past(sel_cnt))); // R8

  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_cmd |=> $stable(snap_q)); // R8

  AST_HIT_SETS_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_hit != '0) |=> ((int_act & $past(thr_hit)) == $past(thr_hit))); // R9

  AST_CLR_DROPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> ((int_en & $past(reg_wdata[NUM_CTRS-1:0])) == '0)); // R10

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(thr_hit) != '0 || $past(en_wr))); // R11

endmodule

bind perf_counter_bank pcb_checker #(
  .NUM_CTRS  (NUM_CTRS),
  .CIDX_W    (CIDX_W),
  .CTR_W     (CTR_W),
  .IW        (IW),
  .SIZE_CODE (SIZE_CODE)
) u_pcb_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_we     (reg_we),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .run_q      (run_q),
  .idx_q      (idx_q),
  .sel_cfg    (sel_cfg),
  .sel_cnt    (sel_cnt),
  .sel_inc    (sel_inc),
  .snap_q     (snap_q),
  .cnt_wr_sel (cnt_wr_sel),
  .idx_wr     (idx_wr),
  .snap_cmd   (snap_cmd),
  .ctr_inc    (ctr_inc),
  .thr_hit    (thr_hit),
  .int_en     (int_en),
  .int_act    (int_act),
  .irq        (irq)
);

// File: tb/perf_counter_bank_test.sv
module perf_counter_bank_test;

  localparam int N_CTR  = 4;
  localparam int N_COND = 4;

  localparam logic [3:0] A_BUILD = 4'd0,  A_INDEX = 4'd1,  A_CTRL = 4'd2,  A_CFG = 4'd3,
                         A_CLO   = 4'd4,  A_CHI   = 4'd5,  A_SLO  = 4'd6,  A_SHI = 4'd7,
                         A_TLO   = 4'd8,  A_THI   = 4'd9,  A_IEN  = 4'd10, A_IACT = 4'd11;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_we = 1'b0;
  logic [3:0]        reg_addr = 4'd0;
  logic [31:0]       reg_wdata = 32'd0;
  logic [31:0]       reg_rdata;
  logic [N_COND-1:0] cond_in = '0;
  logic              priv_user = 1'b0;
  logic              irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  perf_counter_bank #(.NUM_CTRS(N_CTR), .NUM_COND(N_COND), .SIZE_CODE(0)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cond_in(cond_in),
    .priv_user(priv_user), .irq(irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse(input logic [N_COND-1:0] pat, input int n);
    cond_in = pat;
    repeat (n) @(negedge clk);
    cond_in = '0;
  endtask

  function automatic int exp_count(int k, int q, bit pu, logic [N_COND-1:0] pat, int n);
    bit ok;
    ok = (q == 0) || (q == 1 && !pu) || (q == 2 && pu);
    return (k != 0 && pat[k] && ok) ? n : 0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_INDEX, v); chk("R1 index", v, 0);
    rd(A_CTRL, v);  chk("R1 ctrl", v, 0);
    rd(A_CFG, v);   chk("R1 cfg", v, 0);
    rd(A_CLO, v);   chk("R1 count", v, 0);
    rd(A_TLO, v);   chk("R1 threshold", v, 0);
    rd(A_IEN, v);   chk("R1 int_en", v, 0);
    rd(A_IACT, v);  chk("R1 int_act", v, 0);
    chk("R1 irq", irq, 0);

    // R3 build word
    rd(A_BUILD, v); chk("R3 build", v, 32'h0001_0401);

    // R4 control bits
    wr(A_CTRL, 32'hABCD_0003);
    rd(A_CTRL, v); chk("R4 ctrl readback", v, 32'hABCD_0001);

    // R2 index selection
    wr(A_INDEX, 5);
    rd(A_INDEX, v); chk("R2 index low bits", v, 1);
    wr(A_INDEX, 2); wr(A_CLO, 77);
    wr(A_INDEX, 3);
    rd(A_CLO, v); chk("R2 other counter untouched", v, 0);
    wr(A_INDEX, 2);
    rd(A_CLO, v); chk("R2 selected counter", v, 77);

    // R5 / R6 sweep: counter x condition x qualifier x mode x pattern
    for (int c = 0; c < N_CTR; c++) begin
      wr(A_INDEX, c);
      for (int k = 0; k < N_COND; k++)
        for (int q = 0; q < 4; q++)
          for (int pu = 0; pu < 2; pu++)
            for (int p = 0; p < 2; p++) begin
              logic [N_COND-1:0] pat;
              pat = (p == 0) ? 4'b1010 : 4'b0101;
              wr(A_CFG, (32'(q) << 30) | 32'(k));
              wr(A_CLO, 0); wr(A_CHI, 0);
              priv_user = pu[0];
              pulse(pat, 3);
              rd(A_CLO, v);
              chk((k == 0) ? "R6 never condition" : "R5 count rule", v,
                  exp_count(k, q, pu[0], pat, 3));
            end
    end
    priv_user = 1'b0;

    // R4 stopped counters
    wr(A_INDEX, 0); wr(A_CFG, 1); wr(A_CLO, 0);
    wr(A_CTRL, 0);
    pulse('1, 3);
    rd(A_CLO, v); chk("R4 run clear holds", v, 0);
    wr(A_CTRL, 1);

    // R7 preload, wrap and width
    wr(A_CLO, 32'hFFFF_FFFF); wr(A_CHI, 5);
    rd(A_CHI, v); chk("R7 high bits zero", v, 0);
    pulse(4'b0010, 2);
    rd(A_CLO, v); chk("R7 wrap", v, 1);
    wr(A_IACT, 32'hF);

    // R8 snapshot
    wr(A_CLO, 32'h1234_5678);
    wr(A_CTRL, 3);
    rd(A_SLO, v); chk("R8 snap low", v, 32'h1234_5678);
    rd(A_SHI, v); chk("R8 snap high", v, 0);
    rd(A_CTRL, v); chk("R8 snap bit reads 0", v, 1);
    wr(A_CLO, 0); wr(A_SLO, 5);
    rd(A_SLO, v); chk("R8 snap held", v, 32'h1234_5678);

    // R9 / R11 threshold and interrupt
    wr(A_INDEX, 1); wr(A_CFG, 1);
    wr(A_CLO, 10); wr(A_CHI, 0);
    wr(A_TLO, 13); wr(A_THI, 0);
    wr(A_IEN, 2);
    pulse(4'b0010, 2);
    rd(A_IACT, v); chk("R9 below threshold", v, 0);
    chk("R11 irq low", irq, 0);
    pulse(4'b0010, 1);
    rd(A_IACT, v); chk("R9 threshold reached", v, 2);
    chk("R11 irq high", irq, 1);

    // R10 write-1-to-clear
    wr(A_IACT, 2);
    rd(A_IACT, v); chk("R10 act cleared", v, 0);
    rd(A_IEN, v);  chk("R10 enable cleared", v, 0);
    chk("R10 irq low", irq, 0);

    // R11 active without enable
    wr(A_CLO, 20); wr(A_TLO, 21);
    pulse(4'b0010, 1);
    rd(A_IACT, v); chk("R11 act set", v, 2);
    chk("R11 irq masked", irq, 0);
    wr(A_IEN, 2);
    chk("R11 irq after enable", irq, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule